// File: doc/BRIEF.md
# Variable Page-Size Address Translation Buffer

This block is a fully associative translation buffer. It turns a virtual address into a physical address. Each lookup presents a virtual address, an address space tag, a privilege mode and an access kind. In the same cycle, with no clock in the path, the block returns a hit flag, the translated physical address and a protection-fault flag.

Every entry carries its own page size, so pages from 4 KB up to the whole address space sit side by side in one array. The address space tag is part of the match key. A task switch therefore only changes the tag on the lookup port, and no entries need to be invalidated.

A write port loads or invalidates one entry, chosen by index. Refilling entries after a miss and choosing which entry to replace are left to the surrounding logic.

Top module: `vpsz_tlb`

## Requirements
- R1: A lookup hits when a valid entry has the same address space tag and agrees with the lookup address in every bit at or above position 12+size. The physical address is then the entry's physical address above that position, and the lookup address's own bits below it.
- R2: The page size of an entry is 4 KB shifted left by its 6-bit size field. Entries of different sizes translate correctly side by side in the same array.
- R3: An entry whose address space tag differs from the lookup tag never hits, even when the address matches.
- R4: Each entry has three permission bits for user mode and three for supervisor mode: bit 0 read, bit 1 write, bit 2 execute. The mode input (1 = supervisor) selects which three bits apply.
- R5: The access kind is encoded 0 = read, 1 = write, 2 = execute, and 3 is reserved. A hit whose selected permission bit for the access kind is 0 raises the fault output. A reserved access kind always faults on a hit.
- R6: Supervisor accesses are checked against the supervisor bits and are refused when the relevant bit is clear.
- R7: When no valid entry matches, the hit output is 0, the fault output is 0 and the physical address output is 0.
- R8: When several valid entries match, the entry with the lowest index supplies the translation and the permissions.
- R9: An entry whose 12+size exceeds the virtual address width never hits.
- R10: A write with the enable high loads all fields of the indexed entry and sets its valid bit to the write's valid input. The change is visible at the lookup outputs only after the next rising clock edge. The lookup path is combinational.
- R11: Reset (active low) clears the valid bit of every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | $clog2(ENTRIES) | Index of the entry written |
| wr_valid | input | 1 | Valid bit loaded (0 invalidates) |
| wr_va | input | VA_W | Virtual page base of the entry |
| wr_pa | input | PA_W | Physical page base of the entry |
| wr_asid | input | ASID_W | Address space tag of the entry |
| wr_size | input | SIZE_W | Page size code (4 KB << code) |
| wr_uperm | input | 3 | User permissions {exec, write, read} |
| wr_sperm | input | 3 | Supervisor permissions {exec, write, read} |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address space tag |
| lk_super | input | 1 | 1 = supervisor access, 0 = user |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 exec, 3 reserved |
| lk_hit | output | 1 | A valid entry matched |
| lk_pa | output | PA_W | Translated physical address |
| lk_fault | output | 1 | Hit refused by the permission check |

## Verification
The bench uses the default parameters: 32 entries and 32-bit virtual and physical addresses. Entry index 31 is therefore reachable for the priority tests. With a 32-bit address, size code 20 already gives a page that covers the whole address space, and code 21 is the first oversize code, so both edges of the size range can be tested cheaply. The 8-bit tag lets entries in six distinct address spaces share the array while one mapping is checked against both privilege modes.

// File: rtl/vpsz_tlb_pkg.sv
package vpsz_tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
  localparam int PERM_W_BITS = 3;
endpackage

// File: rtl/vpsz_tlb_store.sv
module vpsz_tlb_store #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int SIZE_W  = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic                             wr_valid,
  input  logic [VA_W-1:0]                  wr_va,
  input  logic [PA_W-1:0]                  wr_pa,
  input  logic [ASID_W-1:0]                wr_asid,
  input  logic [SIZE_W-1:0]                wr_size,
  input  logic [2:0]                       wr_uperm,
  input  logic [2:0]                       wr_sperm,
  output logic [ENTRIES-1:0]               ent_valid,
  output logic [ENTRIES-1:0][VA_W-1:0]     ent_va,
  output logic [ENTRIES-1:0][PA_W-1:0]     ent_pa,
  output logic [ENTRIES-1:0][ASID_W-1:0]   ent_asid,
  output logic [ENTRIES-1:0][SIZE_W-1:0]   ent_size,
  output logic [ENTRIES-1:0][2:0]          ent_uperm,
  output logic [ENTRIES-1:0][2:0]          ent_sperm
);
  logic [ENTRIES-1:0] slot_we;
  logic [ENTRIES-1:0] valid_d;

  // next-state: one-hot write enable and next valid vector
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      slot_we[i] = wr_en && (wr_idx == IDX_W'(i));
      valid_d[i] = slot_we[i] ? wr_valid : ent_valid[i];
    end
  end

  // valid bits: the only state that needs a reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
    end else if (wr_en) begin
      ent_valid <= valid_d;
    end
  end

  // entry payload: enabled capture, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (slot_we[i]) begin
        ent_va[i]    <= wr_va;
        ent_pa[i]    <= wr_pa;
        ent_asid[i]  <= wr_asid;
        ent_size[i]  <= wr_size;
        ent_uperm[i] <= wr_uperm;
        ent_sperm[i] <= wr_sperm;
      end
    end
  end

  // R10: a write lands in the addressed slot on the next edge
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_valid[$past(wr_idx)] == $past(wr_valid)));
endmodule

// File: rtl/vpsz_tlb_match.sv
module vpsz_tlb_match #(
  parameter int ENTRIES    = 32,
  parameter int VA_W       = 32,
  parameter int ASID_W     = 8,
  parameter int SIZE_W     = 6,
  parameter int PAGE_SHIFT = 12,
  localparam int OFF_W     = SIZE_W + 2
) (
  input  logic [VA_W-1:0]                  lk_va,
  input  logic [ASID_W-1:0]                lk_asid,
  input  logic [ENTRIES-1:0]               ent_valid,
  input  logic [ENTRIES-1:0][VA_W-1:0]     ent_va,
  input  logic [ENTRIES-1:0][ASID_W-1:0]   ent_asid,
  input  logic [ENTRIES-1:0][SIZE_W-1:0]   ent_size,
  output logic [ENTRIES-1:0]               match_vec
);
  localparam logic [OFF_W-1:0] VA_W_L  = OFF_W'(VA_W);
  localparam logic [OFF_W-1:0] SHIFT_L = OFF_W'(PAGE_SHIFT);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [OFF_W-1:0] off;
    logic             size_ok;
    logic [VA_W-1:0]  cmp_mask;
    logic             va_eq;
    logic             tag_eq;

    always_comb begin
      off      = SHIFT_L + OFF_W'(ent_size[g]);
      size_ok  = (off <= VA_W_L);
      cmp_mask = ~((VA_W'(1) << off) - VA_W'(1));
      va_eq    = (((lk_va ^ ent_va[g]) & cmp_mask) == '0);
      tag_eq   = (lk_asid == ent_asid[g]);
      match_vec[g] = ent_valid[g] && size_ok && va_eq && tag_eq;
    end
  end
endmodule

// File: rtl/vpsz_tlb_pick.sv
module vpsz_tlb_pick #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any,
  output logic [IDX_W-1:0]   sel
);
  // lowest index wins
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i] && !any) begin
        any = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vpsz_tlb.sv
module vpsz_tlb
  import vpsz_tlb_pkg::*;
#(
  parameter int ENTRIES    = 32,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int ASID_W     = 8,
  parameter int SIZE_W     = 6,
  parameter int PAGE_SHIFT = 12,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int OFF_W     = SIZE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [VA_W-1:0]   wr_va,
  input  logic [PA_W-1:0]   wr_pa,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [2:0]        wr_uperm,
  input  logic [2:0]        wr_sperm,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_super,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_fault
);
  localparam logic [OFF_W-1:0] VA_W_L  = OFF_W'(VA_W);
  localparam logic [OFF_W-1:0] SHIFT_L = OFF_W'(PAGE_SHIFT);

  logic [ENTRIES-1:0]              ent_valid;
  logic [ENTRIES-1:0][VA_W-1:0]    ent_va;
  logic [ENTRIES-1:0][PA_W-1:0]    ent_pa;
  logic [ENTRIES-1:0][ASID_W-1:0]  ent_asid;
  logic [ENTRIES-1:0][SIZE_W-1:0]  ent_size;
  logic [ENTRIES-1:0][2:0]         ent_uperm;
  logic [ENTRIES-1:0][2:0]         ent_sperm;
  logic [ENTRIES-1:0]              match_vec;
  logic                            any;
  logic [IDX_W-1:0]                sel;

  vpsz_tlb_store #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W),
    .ASID_W(ASID_W), .SIZE_W(SIZE_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_va(wr_va), .wr_pa(wr_pa), .wr_asid(wr_asid),
    .wr_size(wr_size), .wr_uperm(wr_uperm), .wr_sperm(wr_sperm),
    .ent_valid(ent_valid), .ent_va(ent_va), .ent_pa(ent_pa),
    .ent_asid(ent_asid), .ent_size(ent_size),
    .ent_uperm(ent_uperm), .ent_sperm(ent_sperm)
  );

  vpsz_tlb_match #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W),
    .SIZE_W(SIZE_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_match (
    .lk_va(lk_va), .lk_asid(lk_asid),
    .ent_valid(ent_valid), .ent_va(ent_va),
    .ent_asid(ent_asid), .ent_size(ent_size),
    .match_vec(match_vec)
  );

  vpsz_tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .match_vec(match_vec), .any(any), .sel(sel)
  );

  // resolve: permissions and address composition for the chosen entry
  logic [2:0]       perm;
  logic             allowed;
  logic [OFF_W-1:0] sel_off;
  logic [PA_W-1:0]  pass_mask;

  always_comb begin
    perm = lk_super ? ent_sperm[sel] : ent_uperm[sel];
    unique case (acc_e'(lk_acc))
      ACC_READ:  allowed = perm[PERM_R];
      ACC_WRITE: allowed = perm[PERM_W];
      ACC_EXEC:  allowed = perm[PERM_X];
      default:   allowed = 1'b0;
    endcase
    sel_off   = SHIFT_L + OFF_W'(ent_size[sel]);
    pass_mask = (PA_W'(1) << sel_off) - PA_W'(1);
    lk_hit    = any;
    lk_fault  = any && !allowed;
    lk_pa     = any ? ((ent_pa[sel] & ~pass_mask) | (PA_W'(lk_va) & pass_mask))
                    : '0;
  end

  // R5: a fault is only ever raised on a hit
  a_r5_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  // R7: no match means quiet outputs
  a_r7_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec == '0) |-> (!lk_hit && !lk_fault && lk_pa == '0));

  // R8: the chosen entry matches and nothing below it does
  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (match_vec[sel] &&
                ((match_vec & ((ENTRIES'(1) << sel) - ENTRIES'(1))) == '0)));

  // R9: an oversize entry never supplies a hit
  a_r9_oversize_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (sel_off <= VA_W_L));

  // R1: page offset bits pass straight through
  a_r1_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (((lk_pa ^ PA_W'(lk_va)) & pass_mask) == '0));
endmodule

// File: tb/vpsz_tlb_tb.sv
module vpsz_tlb_tb;
  localparam int ENTRIES = 32;
  localparam int IDX_W   = 5;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic        wr_valid;
  logic [31:0] wr_va;
  logic [31:0] wr_pa;
  logic [7:0]  wr_asid;
  logic [5:0]  wr_size;
  logic [2:0]  wr_uperm;
  logic [2:0]  wr_sperm;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic        lk_super;
  logic [1:0]  lk_acc;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic        lk_fault;

  int checks = 0;
  int errors = 0;

  vpsz_tlb u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_va(wr_va), .wr_pa(wr_pa), .wr_asid(wr_asid),
    .wr_size(wr_size), .wr_uperm(wr_uperm), .wr_sperm(wr_sperm),
    .lk_va(lk_va), .lk_asid(lk_asid), .lk_super(lk_super), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_fault(lk_fault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        sup;
    logic [1:0]  acc;
    logic        hit;
    logic        fault;
    logic [31:0] pa;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1ABC, 8'd1, 1'b0, 2'd0, 1'b1, 1'b0, 32'h8000_0ABC, 8'd1},  // R1 R8 4K, e0 beats e9
    '{32'h0000_1ABC, 8'd1, 1'b0, 2'd1, 1'b1, 1'b1, 32'h8000_0ABC, 8'd5},  // R5 user write refused
    '{32'h0000_1ABC, 8'd1, 1'b1, 2'd1, 1'b1, 1'b0, 32'h8000_0ABC, 8'd4},  // R4 supervisor set used
    '{32'h0000_1ABC, 8'd1, 1'b1, 2'd2, 1'b1, 1'b1, 32'h8000_0ABC, 8'd6},  // R6 sup exec refused
    '{32'h0001_F123, 8'd1, 1'b0, 2'd2, 1'b1, 1'b0, 32'h4002_F123, 8'd2},  // R2 64K page
    '{32'h0001_F123, 8'd1, 1'b1, 2'd2, 1'b1, 1'b1, 32'h4002_F123, 8'd6},  // R6
    '{32'h0001_0456, 8'd2, 1'b0, 2'd1, 1'b1, 1'b0, 32'h1234_5456, 8'd3},  // R3 same VA other tag
    '{32'h0001_1456, 8'd2, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 8'd7},  // R7 beyond 4K page
    '{32'h0001_0456, 8'd2, 1'b1, 2'd0, 1'b1, 1'b1, 32'h1234_5456, 8'd6},  // R6 sup no rights
    '{32'h007F_FFFC, 8'd1, 1'b1, 2'd0, 1'b1, 1'b0, 32'h0C3F_FFFC, 8'd2},  // R2 4M page
    '{32'h007F_FFFC, 8'd1, 1'b0, 2'd0, 1'b1, 1'b1, 32'h0C3F_FFFC, 8'd4},  // R4 user set used
    '{32'h0080_0000, 8'd1, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 8'd7},  // R7 just past 4M
    '{32'h1FED_CBA9, 8'd3, 1'b0, 2'd1, 1'b1, 1'b0, 32'h2FED_CBA9, 8'd2},  // R2 256M page
    '{32'h1FED_CBA9, 8'd3, 1'b0, 2'd2, 1'b1, 1'b1, 32'h2FED_CBA9, 8'd5},  // R5
    '{32'hDEAD_BEEF, 8'd5, 1'b0, 2'd0, 1'b1, 1'b0, 32'hDEAD_BEEF, 8'd1},  // R1 whole-space page
    '{32'hDEAD_BEEF, 8'd5, 1'b0, 2'd1, 1'b1, 1'b1, 32'hDEAD_BEEF, 8'd5},  // R5
    '{32'h0000_0010, 8'd4, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 8'd9},  // R9 size code 21
    '{32'h7000_0FFF, 8'd6, 1'b0, 2'd2, 1'b1, 1'b0, 32'h0ABC_DFFF, 8'd8},  // R8 last slot
    '{32'h1234_5678, 8'd5, 1'b0, 2'd3, 1'b1, 1'b1, 32'h1234_5678, 8'd5},  // R5 reserved kind
    '{32'h0000_1ABC, 8'd9, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 8'd3}   // R3 unknown tag
  };

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got hit/fault/pa=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [31:0] va, input logic [31:0] pa,
                     input logic [7:0] asid, input logic [5:0] size,
                     input logic [2:0] up, input logic [2:0] sp, input logic vld);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = vld;
    wr_va = va; wr_pa = pa; wr_asid = asid; wr_size = size;
    wr_uperm = up; wr_sperm = sp;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid,
                      input logic sup, input logic [1:0] acc);
    lk_va = va; lk_asid = asid; lk_super = sup; lk_acc = acc;
    #1;
  endtask

  logic wd_fired = 1'b0;
  initial begin
    #(4 * 100000);
    wd_fired = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0;
    wr_va = '0; wr_pa = '0; wr_asid = '0; wr_size = '0;
    wr_uperm = '0; wr_sperm = '0;
    lk_va = '0; lk_asid = '0; lk_super = 1'b0; lk_acc = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state: nothing hits
    look(32'h0000_1ABC, 8'd1, 1'b0, 2'd0);
    check("R11 after reset", {lk_hit, lk_fault, lk_pa}, 34'h0);
    look(32'h0000_0000, 8'd0, 1'b1, 2'd0);
    check("R11 after reset zero key", {lk_hit, lk_fault, lk_pa}, 34'h0);

    // fill: perms are {exec, write, read}
    put(0,  32'h0000_1000, 32'h8000_0000, 8'd1, 6'd0,  3'b001, 3'b011, 1'b1);
    put(1,  32'h0001_0000, 32'h4002_0000, 8'd1, 6'd4,  3'b101, 3'b001, 1'b1);
    put(2,  32'h0001_0000, 32'h1234_5000, 8'd2, 6'd0,  3'b111, 3'b000, 1'b1);
    put(3,  32'h0040_0000, 32'h0C00_0000, 8'd1, 6'd10, 3'b000, 3'b111, 1'b1);
    put(5,  32'h1000_0000, 32'h2000_0000, 8'd3, 6'd16, 3'b011, 3'b011, 1'b1);
    put(7,  32'h0000_0000, 32'h5555_0000, 8'd4, 6'd21, 3'b111, 3'b111, 1'b1);
    put(8,  32'h0000_0000, 32'h0000_0000, 8'd5, 6'd20, 3'b001, 3'b001, 1'b1);
    put(9,  32'h0000_1000, 32'h9999_9000, 8'd1, 6'd0,  3'b111, 3'b111, 1'b1);
    put(31, 32'h7000_0000, 32'h0ABC_D000, 8'd6, 6'd0,  3'b111, 3'b111, 1'b1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      string tag;
      look(VECS[v].va, VECS[v].asid, VECS[v].sup, VECS[v].acc);
      tag = $sformatf("R%0d vector %0d", VECS[v].req, v);
      check(tag, {lk_hit, lk_fault, lk_pa}, {VECS[v].hit, VECS[v].fault, VECS[v].pa});
      #1;
    end

    // R10: invalidate e0, old value visible until the edge, then e9 takes over (R8)
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd0; wr_valid = 1'b0;
    look(32'h0000_1ABC, 8'd1, 1'b0, 2'd0);
    check("R10 before edge", {lk_hit, lk_fault, lk_pa}, {2'b10, 32'h8000_0ABC});
    @(posedge clk);
    #1 wr_en = 1'b0;
    check("R10 after edge", {lk_hit, lk_fault, lk_pa}, {2'b10, 32'h9999_9ABC});

    // R10: refill e0 with a new physical base and check the lookup
    put(0, 32'h0000_1000, 32'h6000_0000, 8'd1, 6'd0, 3'b001, 3'b001, 1'b1);
    look(32'h0000_1ABC, 8'd1, 1'b0, 2'd0);
    check("R10 refill", {lk_hit, lk_fault, lk_pa}, {2'b10, 32'h6000_0ABC});

    // R11: reset mid-run drops every entry
    @(negedge clk) rst_n = 1'b0;
    look(32'hDEAD_BEEF, 8'd5, 1'b0, 2'd0);
    check("R11 reset clears whole-space entry", {lk_hit, lk_fault, lk_pa}, 34'h0);
    @(negedge clk) rst_n = 1'b1;
    look(32'h7000_0FFF, 8'd6, 1'b0, 2'd2);
    check("R11 reset clears last slot", {lk_hit, lk_fault, lk_pa}, 34'h0);

    if (!wd_fired) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule